// File: doc/BRIEF.md
# Processor Boot Handoff Controller

This block decides whether a soft processor or a host-side user port drives a shared external SRAM. After reset the host owns the memory. It loads a program and can read back any location. Meanwhile the processor runs a boot loop that keeps reading one fixed check-ready address. The block fakes the data for that one address. It answers with zero, so the loop keeps spinning, until the host sends a start command. From then on it answers with a word whose bit 1 is set, so the loop exits and jumps to the program.

The first poll seen after reset produces a one-cycle ready pulse toward the host. A start command gives the SRAM to the processor, and a halt command takes it back. When the processor writes the designated result address, the write lands in SRAM. The block also raises a one-cycle done pulse and returns ownership to the host, which then reads the results. The processor goes back to polling.

Top module: `boot_handoff_ctrl`

## Requirements
- R1: A processor poll is a cycle with `cpu_rd_i` high and `cpu_addr_i` exactly equal to `CHECK_ADDR`. A read of any other address never produces `ready_o`.
- R2: While `go_o` is low, a poll returns all zeros on `cpu_rdata_o`, whatever `sram_rdata_i` holds.
- R3: The first poll after reset raises `ready_o` for exactly one cycle, on the clock edge that ends the poll cycle. Later polls raise no further `ready_o` until the next reset.
- R4: While `go_o` is low, `sram_addr_o`, `sram_wdata_o`, `sram_we_o` and `sram_oe_o` follow the user port (`usr_addr_i`, `usr_wdata_i`, `usr_we_i`, `usr_oe_i`). While `go_o` is high, they follow the processor port (`cpu_addr_i`, `cpu_wdata_i`, `cpu_we_i`, `cpu_rd_i`).
- R5: The side that does not own the SRAM is isolated. While `go_o` is low, `cpu_rdata_o` is zero. While `go_o` is high, `usr_rdata_o` is zero. The owning side sees `sram_rdata_i`, except for a processor poll.
- R6: A command is accepted on a clock edge with `cmd_valid_i` high. Opcode 0x50 sets `go_o` on that edge and opcode 0x54 clears it. All other opcodes leave `go_o` unchanged.
- R7: While `go_o` is high, a poll returns `READY_WORD` (default 32'h2, bit 1 set) on `cpu_rdata_o` instead of SRAM data.
- R8: A processor write (`cpu_we_i`) to `RESULT_ADDR` while `go_o` is high does three things. It passes to SRAM. It clears `go_o` on that edge. It raises `done_o` for exactly one cycle after that edge. The same write while `go_o` is low has no effect.
- R9: If a clear (a halt or a result write) and a start arrive on the same edge, the clear wins.
- R10: Asynchronous active-low reset `rst_ni` clears `go_o` and the ready-sent record, so the SRAM goes to the user side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cmd_valid_i | input | 1 | host command strobe |
| cmd_op_i | input | 8 | host command opcode |
| usr_addr_i | input | AW | user SRAM address |
| usr_wdata_i | input | DW | user write data |
| usr_we_i | input | 1 | user write enable |
| usr_oe_i | input | 1 | user read/output enable |
| usr_rdata_o | output | DW | read data to user |
| cpu_addr_i | input | AW | processor address |
| cpu_wdata_i | input | DW | processor write data |
| cpu_rd_i | input | 1 | processor read strobe |
| cpu_we_i | input | 1 | processor write strobe |
| cpu_rdata_o | output | DW | read data to processor |
| sram_addr_o | output | AW | SRAM address |
| sram_wdata_o | output | DW | SRAM write data |
| sram_we_o | output | 1 | SRAM write enable |
| sram_oe_o | output | 1 | SRAM output enable |
| sram_rdata_i | input | DW | SRAM read data |
| ready_o | output | 1 | one-shot ready notification |
| done_o | output | 1 | result-written notification |
| go_o | output | 1 | processor owns SRAM |

## Verification
The ownership mux is swept over every address of an 8-bit configuration with both owners. Each sweep uses address-dependent data, so a wrong select or a leaking data path shows up as a mismatch.

Processor reads of every non-check address are tried before the first poll, which separates exact address matching from a partial decode. All 256 opcodes are tried with go low and with go high, which separates the two real commands from ignored ones.

Polls are issued before and after start and after a reset. These cases tell apart the zero answer, the release word and the one-shot ready pulse. Result writes with go high and with go low tell a real done from an ignored write.

// File: rtl/boot_handoff_pkg.sv
package boot_handoff_pkg;
  localparam logic [7:0] OP_START = 8'h50;
  localparam logic [7:0] OP_HALT  = 8'h54;

  typedef enum logic {OWN_USER = 1'b0, OWN_CPU = 1'b1} owner_e;
endpackage

// File: rtl/bh_poll_detect.sv
module bh_poll_detect #(
  parameter int AW = 20,
  parameter logic [AW-1:0] CHECK_ADDR = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_rd_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic          poll_o,
  output logic          ready_o
);
  logic sent_q, ready_q;

  assign poll_o  = cpu_rd_i && (cpu_addr_i == CHECK_ADDR);
  assign ready_o = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= poll_o && !sent_q;
      if (poll_o) sent_q <= 1'b1;
    end
  end

  // R3
  ready_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sent_q) |-> !ready_o);
endmodule

// File: rtl/bh_go_ctrl.sv
module bh_go_ctrl
  import boot_handoff_pkg::*;
#(
  parameter int AW = 20,
  parameter logic [AW-1:0] RESULT_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_op_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  output owner_e        owner_o,
  output logic          done_o
);
  logic go_q, done_q, start, halt, res_wr;

  assign start  = cmd_valid_i && (cmd_op_i == OP_START);
  assign halt   = cmd_valid_i && (cmd_op_i == OP_HALT);
  assign res_wr = go_q && cpu_we_i && (cpu_addr_i == RESULT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= res_wr;
      if (halt || res_wr) go_q <= 1'b0;   // clear wins over start
      else if (start)     go_q <= 1'b1;
    end
  end

  assign owner_o = go_q ? OWN_CPU : OWN_USER;
  assign done_o  = done_q;

  // R6
  start_sets_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !halt && !res_wr) |=> (owner_o == OWN_CPU));
  // R9
  halt_clears_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> (owner_o == OWN_USER));
  // R8
  done_clears_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (owner_o == OWN_USER));
endmodule

// File: rtl/bh_sram_mux.sv
module bh_sram_mux
  import boot_handoff_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  owner_e        owner_i,
  input  logic [AW-1:0] usr_addr_i,
  input  logic [DW-1:0] usr_wdata_i,
  input  logic          usr_we_i,
  input  logic          usr_oe_i,
  output logic [DW-1:0] usr_rdata_o,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_we_i,
  input  logic          cpu_rd_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_wdata_o,
  output logic          sram_we_o,
  output logic          sram_oe_o,
  input  logic [DW-1:0] sram_rdata_i
);
  always_comb begin
    if (owner_i == OWN_CPU) begin
      sram_addr_o  = cpu_addr_i;
      sram_wdata_o = cpu_wdata_i;
      sram_we_o    = cpu_we_i;
      sram_oe_o    = cpu_rd_i;
      cpu_rdata_o  = sram_rdata_i;
      usr_rdata_o  = '0;
    end else begin
      sram_addr_o  = usr_addr_i;
      sram_wdata_o = usr_wdata_i;
      sram_we_o    = usr_we_i;
      sram_oe_o    = usr_oe_i;
      cpu_rdata_o  = '0;
      usr_rdata_o  = sram_rdata_i;
    end
  end
endmodule

// File: rtl/boot_handoff_ctrl.sv
module boot_handoff_ctrl
  import boot_handoff_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter logic [AW-1:0] CHECK_ADDR  = '1,
  parameter logic [AW-1:0] RESULT_ADDR = '0,
  parameter logic [DW-1:0] READY_WORD  = DW'(2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_op_i,
  input  logic [AW-1:0] usr_addr_i,
  input  logic [DW-1:0] usr_wdata_i,
  input  logic          usr_we_i,
  input  logic          usr_oe_i,
  output logic [DW-1:0] usr_rdata_o,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_rd_i,
  input  logic          cpu_we_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_wdata_o,
  output logic          sram_we_o,
  output logic          sram_oe_o,
  input  logic [DW-1:0] sram_rdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          go_o
);
  owner_e        owner;
  logic          poll;
  logic [DW-1:0] mux_cpu_rdata;

  bh_poll_detect #(.AW(AW), .CHECK_ADDR(CHECK_ADDR)) u_poll (
    .clk_i, .rst_ni, .cpu_rd_i, .cpu_addr_i,
    .poll_o(poll), .ready_o
  );

  bh_go_ctrl #(.AW(AW), .RESULT_ADDR(RESULT_ADDR)) u_go (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cpu_we_i, .cpu_addr_i,
    .owner_o(owner), .done_o
  );

  bh_sram_mux #(.AW(AW), .DW(DW)) u_mux (
    .owner_i(owner),
    .usr_addr_i, .usr_wdata_i, .usr_we_i, .usr_oe_i, .usr_rdata_o,
    .cpu_addr_i, .cpu_wdata_i, .cpu_we_i, .cpu_rd_i,
    .cpu_rdata_o(mux_cpu_rdata),
    .sram_addr_o, .sram_wdata_o, .sram_we_o, .sram_oe_o, .sram_rdata_i
  );

  assign go_o = (owner == OWN_CPU);

  // poll answer overrides SRAM data
  always_comb begin
    if (poll) cpu_rdata_o = go_o ? READY_WORD : '0;
    else      cpu_rdata_o = mux_cpu_rdata;
  end

  // R2
  poll_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll && !go_o) |-> (cpu_rdata_o == '0));
  // R7
  poll_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll && go_o) |-> (cpu_rdata_o == READY_WORD));
  // R5
  cpu_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_o |-> (cpu_rdata_o == '0));
  // R5
  usr_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (usr_rdata_o == '0));
endmodule

// File: tb/boot_handoff_ctrl_test.sv
module boot_handoff_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] CHK = 8'hFC;
  localparam logic [AW-1:0] RES = 8'h40;
  localparam logic [DW-1:0] RDY = 16'h0002;

  logic clk = 0, rst_ni = 0;
  logic cmd_valid_i = 0;
  logic [7:0] cmd_op_i = 0;
  logic [AW-1:0] usr_addr_i = 0, cpu_addr_i = 0, sram_addr_o;
  logic [DW-1:0] usr_wdata_i = 0, cpu_wdata_i = 0, sram_rdata_i = 0;
  logic [DW-1:0] usr_rdata_o, cpu_rdata_o, sram_wdata_o;
  logic usr_we_i = 0, usr_oe_i = 0, cpu_rd_i = 0, cpu_we_i = 0;
  logic sram_we_o, sram_oe_o, ready_o, done_o, go_o;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  boot_handoff_ctrl #(.AW(AW), .DW(DW), .CHECK_ADDR(CHK), .RESULT_ADDR(RES),
                      .READY_WORD(RDY)) uut (.clk_i(clk), .*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cmd(input logic [7:0] op);
    cmd_valid_i = 1; cmd_op_i = op; step(); cmd_valid_i = 0;
  endtask

  initial begin
    #1;
    chk(go_o == 0 && ready_o == 0 && done_o == 0, "R10 reset", {go_o, ready_o, done_o}, 0);
    repeat (3) step();
    rst_ni = 1;
    step();

    // R4/R5 user owns: full address sweep
    for (int a = 0; a < 256; a++) begin
      usr_addr_i = a[7:0]; usr_wdata_i = 16'(a * 257 + 3);
      usr_we_i = a[0]; usr_oe_i = ~a[0]; sram_rdata_i = 16'hA500 | 16'(a);
      cpu_addr_i = RES; cpu_we_i = 1; cpu_wdata_i = 16'hDEAD;
      #1;
      chk(sram_addr_o == a[7:0] && sram_wdata_o == 16'(a * 257 + 3), "R4 user addr/data",
          {sram_addr_o, sram_wdata_o}, {a[7:0], 16'(a * 257 + 3)});
      chk(sram_we_o == a[0] && sram_oe_o == ~a[0], "R4 user strobes", {sram_we_o, sram_oe_o}, {a[0], ~a[0]});
      chk(usr_rdata_o == sram_rdata_i && cpu_rdata_o == 0, "R5 user read/cpu isolated",
          {usr_rdata_o, cpu_rdata_o}, {sram_rdata_i, 16'h0});
    end
    step();
    chk(done_o == 0 && go_o == 0, "R8 result write ignored while go low", {done_o, go_o}, 0);
    cpu_we_i = 0; usr_we_i = 0;

    // R1 non-check reads never notify
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] == CHK) continue;
      cpu_addr_i = a[7:0]; cpu_rd_i = 1; step();
      chk(ready_o == 0, "R1 non-check read", ready_o, 0);
    end
    cpu_rd_i = 0;

    // R2/R3 first poll
    cpu_addr_i = CHK; cpu_rd_i = 1; sram_rdata_i = 16'hFFFF; #1;
    chk(cpu_rdata_o == 0, "R2 poll returns zero", cpu_rdata_o, 0);
    step();
    chk(ready_o == 1, "R3 ready on first poll", ready_o, 1);
    step();
    chk(ready_o == 0, "R3 ready single pulse", ready_o, 0);
    step();
    chk(ready_o == 0 && cpu_rdata_o == 0, "R3 no repeat / R2", {ready_o, cpu_rdata_o}, 0);
    cpu_rd_i = 0;

    // R6 opcodes ignored while go low
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h50 || op == 8'h54) continue;
      cmd(op[7:0]);
      chk(go_o == 0, "R6 ignored opcode go low", go_o, 0);
    end
    cmd(8'h50);
    chk(go_o == 1, "R6 start sets go", go_o, 1);
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h50 || op == 8'h54) continue;
      cmd(op[7:0]);
      chk(go_o == 1, "R6 ignored opcode go high", go_o, 1);
    end

    // R4/R5 cpu owns: sweep
    usr_we_i = 1; usr_oe_i = 0; usr_addr_i = 8'h11;
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] == CHK) continue;
      cpu_addr_i = a[7:0]; cpu_rd_i = 1; cpu_we_i = 0; cpu_wdata_i = 16'(a * 7);
      sram_rdata_i = 16'h3C00 ^ 16'(a);
      #1;
      chk(sram_addr_o == a[7:0] && sram_wdata_o == 16'(a * 7), "R4 cpu addr/data",
          {sram_addr_o, sram_wdata_o}, {a[7:0], 16'(a * 7)});
      chk(sram_we_o == 0 && sram_oe_o == 1, "R4 cpu strobes", {sram_we_o, sram_oe_o}, 2'b01);
      chk(cpu_rdata_o == (16'h3C00 ^ 16'(a)) && usr_rdata_o == 0, "R5 cpu read/user isolated",
          {cpu_rdata_o, usr_rdata_o}, {16'h3C00 ^ 16'(a), 16'h0});
    end
    usr_we_i = 0;

    // R7 release word
    cpu_addr_i = CHK; cpu_rd_i = 1; sram_rdata_i = 16'h0; #1;
    chk(cpu_rdata_o == RDY, "R7 poll returns release word", cpu_rdata_o, RDY);
    step();
    chk(ready_o == 0, "R3 no ready after go", ready_o, 0);
    cpu_rd_i = 0;

    cmd(8'h54);
    chk(go_o == 0, "R6 halt clears go", go_o, 0);

    // R9 halt and start together: halt wins via result write + start
    cmd(8'h50);
    cpu_addr_i = RES; cpu_we_i = 1; cpu_wdata_i = 16'h1234;
    cmd_valid_i = 1; cmd_op_i = 8'h50; #1;
    chk(sram_we_o == 1 && sram_wdata_o == 16'h1234, "R8 result write reaches SRAM",
        {sram_we_o, sram_wdata_o}, {1'b1, 16'h1234});
    step(); cmd_valid_i = 0; cpu_we_i = 0;
    chk(done_o == 1 && go_o == 0, "R8/R9 done and go cleared", {done_o, go_o}, 2'b10);
    step();
    chk(done_o == 0, "R8 done single pulse", done_o, 0);

    cpu_we_i = 1; #1;
    chk(sram_we_o == 0, "R8 cpu write blocked while go low", sram_we_o, 0);
    step(); cpu_we_i = 0;
    chk(done_o == 0, "R8 no done while go low", done_o, 0);

    // R10 reset mid-run
    cmd(8'h50);
    usr_addr_i = 8'h77; cpu_addr_i = 8'h22;
    rst_ni = 0; #1;
    chk(go_o == 0 && sram_addr_o == 8'h77, "R10 reset returns SRAM to user", {go_o, sram_addr_o}, {1'b0, 8'h77});
    step(); rst_ni = 1; step();
    cpu_addr_i = CHK; cpu_rd_i = 1; step(); cpu_rd_i = 0;
    chk(ready_o == 1, "R10 ready re-armed by reset", ready_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule